// File: doc/BRIEF.md
# Segment Access Limit Checker

This block decides, in the same cycle as the request, whether a data read or write through one segment register may proceed. It takes the cached descriptor attributes for that register (valid, present, code/data kind, default-size bit, 4-bit type, limit and base), the offset, the access width, the direction, whether the register is the stack segment, and whether the processor is in protected mode. It returns a fault strobe with its class and the 32-bit linear address.

The block keeps one small state machine per segment register. The machine remembers whether a read and whether a write have already passed the full check since the descriptor was last loaded. Its four states are FL_NONE, FL_RD, FL_WR and FL_RW. A granted read moves FL_NONE to FL_RD or FL_WR to FL_RW. A granted write moves FL_NONE to FL_WR or FL_RD to FL_RW. A reload pulse moves any state back to FL_NONE. Every other cycle stays in the current state.

When the flag for the current direction is set, the block uses a shorter limit comparison. This short check skips the type, present and code/data tests. The full check covers both expand-up and expand-down limit rules.

Top module: `seg_access_checker`

## Requirements
- R1: In protected mode (prot_mode=1), a request with desc_valid=0 raises fault with fault_stack=0 (general protection). This holds whether or not a flag is set.
- R2: In protected mode, a full-path request with desc_present=0 faults with the caller class (R7).
- R3: In protected mode, a full-path write with desc_code_data=0 (system segment) faults.
- R4: acc_size encodes the width: 00 is 1 byte, 01 is 2 bytes, 10 is 4 bytes, and 11 is treated as 4 bytes. Let n be the width. A full-path read of type 0–3, 10, 11, 14 or 15 (expand-up) faults exactly when offset + n − 1 exceeds the limit.
- R5: Types 4–7 are expand-down. Let the bound be 0xFFFFFFFF when desc_big=1 and 0xFFFF otherwise. A full-path read of these types faults when offset ≤ limit, or when offset + n − 1 exceeds the bound.
- R6: A full-path write is accepted only for types 2 and 3 (expand-up) and 6 and 7 (expand-down). A full-path write of any other type faults. A full-path read of types 8, 9, 12 or 13 faults.
- R7: Apart from the R1 case, fault_stack equals is_stack whenever fault is 1.
- R8: rd_ok and wr_ok are 0 after reset. A full-path read or write without fault sets rd_ok or wr_ok respectively, seen from the next cycle. A reload pulse clears both flags. A faulting or idle cycle leaves both flags unchanged.
- R9: With the flag for the direction set, an expand-down type (4–7) faults when (offset − (n − 1)) mod 2^32 ≤ limit. Any other type faults when offset > (limit − (n − 1)) mod 2^32.
- R10: lin_addr equals desc_base + offset modulo 2^32.
- R11: The outputs are combinational in the request cycle. With req=0, both fault and fault_stack are 0.
- R12: Outside protected mode, desc_valid, desc_present and desc_code_data have no effect. The type and limit rules still apply.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reload | input | 1 | Descriptor was reloaded; clears both flags |
| req | input | 1 | Access request this cycle |
| is_write | input | 1 | 1 = write, 0 = read |
| acc_size | input | 2 | Access width code |
| is_stack | input | 1 | Register is the stack segment |
| prot_mode | input | 1 | Protected mode active |
| desc_valid | input | 1 | Cached descriptor valid |
| desc_present | input | 1 | Segment present |
| desc_code_data | input | 1 | 1 = code/data segment, 0 = system |
| desc_big | input | 1 | Default-size bit, selects the expand-down bound |
| desc_type | input | 4 | Segment type code |
| desc_limit | input | 32 | Byte-granular limit |
| desc_base | input | 32 | Segment base |
| offset | input | 32 | Effective offset |
| fault | output | 1 | Access refused |
| fault_stack | output | 1 | 1 = stack fault, 0 = general protection |
| lin_addr | output | 32 | Linear address |
| rd_ok | output | 1 | Read flag state |
| wr_ok | output | 1 | Write flag state |

## Verification
A wrong flag state shows up at the ports on the first request that uses it. A flag stuck at 1 sends requests down the short check, so a write to a read-only type or to an absent segment is granted in that same cycle. A flag that is lost, or one that is not cleared by reload, changes the verdict only where the two limit rules disagree. The bench therefore makes expand-down accesses of 2 bytes just above the limit and wide offsets beyond the 16-bit bound. These are cases where the full and short checks give opposite answers in the cycle right after the flag edge.

// File: rtl/seg_chk_pkg.sv
package seg_chk_pkg;

    typedef enum logic [1:0] {
        FL_NONE = 2'd0,
        FL_RD   = 2'd1,
        FL_WR   = 2'd2,
        FL_RW   = 2'd3
    } flag_state_e;

    typedef enum logic [1:0] {
        K_BAD  = 2'd0,
        K_UP   = 2'd1,
        K_DOWN = 2'd2
    } seg_kind_e;

    // bytes minus one for the width code (11 handled as 4 bytes)
    function automatic logic [1:0] size_span(input logic [1:0] code);
        unique case (code)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd3;
        endcase
    endfunction

    // which limit rule a type obeys for the given direction
    function automatic seg_kind_e type_kind(input logic wr, input logic [3:0] t);
        if (wr) begin
            unique case (t)
                4'd2, 4'd3: return K_UP;
                4'd6, 4'd7: return K_DOWN;
                default:    return K_BAD;
            endcase
        end else begin
            unique case (t)
                4'd0, 4'd1, 4'd2, 4'd3,
                4'd10, 4'd11, 4'd14, 4'd15: return K_UP;
                4'd4, 4'd5, 4'd6, 4'd7:     return K_DOWN;
                default:                    return K_BAD;
            endcase
        end
    endfunction

endpackage

// File: rtl/seg_full_check.sv
module seg_full_check
    import seg_chk_pkg::*;
#(
    parameter int AW    = 32,
    parameter int SUB_W = 16
) (
    input  logic          is_write,
    input  logic          prot_mode,
    input  logic          desc_present,
    input  logic          desc_code_data,
    input  logic          desc_big,
    input  logic [3:0]    desc_type,
    input  logic [AW-1:0] limit,
    input  logic [AW-1:0] offset,
    input  logic [AW-1:0] span,
    output logic          fault
);
    localparam logic [AW-1:0] SMALL_BOUND = {{(AW-SUB_W){1'b0}}, {SUB_W{1'b1}}};

    seg_kind_e     kind;
    logic [AW-1:0] bound;
    logic          attr_fault;
    logic          lim_fault;

    always_comb begin
        kind       = type_kind(is_write, desc_type);
        bound      = desc_big ? {AW{1'b1}} : SMALL_BOUND;
        attr_fault = prot_mode && (!desc_present || (is_write && !desc_code_data));
        lim_fault  = 1'b0;
        unique case (kind)
            K_UP:    lim_fault = (span > limit) || (offset > limit - span);
            K_DOWN:  lim_fault = (offset <= limit) || (offset > bound) ||
                                 ((bound - offset) < span);
            default: lim_fault = 1'b1;
        endcase
        fault = attr_fault || lim_fault;
    end
endmodule

// File: rtl/seg_fast_check.sv
module seg_fast_check #(
    parameter int AW = 32
) (
    input  logic          expand_down,
    input  logic [AW-1:0] limit,
    input  logic [AW-1:0] offset,
    input  logic [AW-1:0] span,
    output logic          fault
);
    always_comb begin
        if (expand_down) fault = (offset - span) <= limit;
        else             fault = offset > (limit - span);
    end
endmodule

// File: rtl/seg_flag_fsm.sv
module seg_flag_fsm
    import seg_chk_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic reload,
    input  logic grant_rd,
    input  logic grant_wr,
    output logic rd_ok,
    output logic wr_ok
);
    flag_state_e state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= FL_NONE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        if (reload) begin
            state_d = FL_NONE;
        end else begin
            unique case (state_q)
                FL_NONE: if (grant_rd) state_d = FL_RD;
                         else if (grant_wr) state_d = FL_WR;
                FL_RD:   if (grant_wr) state_d = FL_RW;
                FL_WR:   if (grant_rd) state_d = FL_RW;
                FL_RW:   state_d = FL_RW;
                default: state_d = FL_NONE;
            endcase
        end
    end

    always_comb begin
        unique case (state_q)
            FL_NONE: begin rd_ok = 1'b0; wr_ok = 1'b0; end
            FL_RD:   begin rd_ok = 1'b1; wr_ok = 1'b0; end
            FL_WR:   begin rd_ok = 1'b0; wr_ok = 1'b1; end
            FL_RW:   begin rd_ok = 1'b1; wr_ok = 1'b1; end
            default: begin rd_ok = 1'b0; wr_ok = 1'b0; end
        endcase
    end
endmodule

// File: rtl/seg_access_checker.sv
module seg_access_checker
    import seg_chk_pkg::*;
#(
    parameter int AW    = 32,
    parameter int SUB_W = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          reload,
    input  logic          req,
    input  logic          is_write,
    input  logic [1:0]    acc_size,
    input  logic          is_stack,
    input  logic          prot_mode,
    input  logic          desc_valid,
    input  logic          desc_present,
    input  logic          desc_code_data,
    input  logic          desc_big,
    input  logic [3:0]    desc_type,
    input  logic [AW-1:0] desc_limit,
    input  logic [AW-1:0] desc_base,
    input  logic [AW-1:0] offset,
    output logic          fault,
    output logic          fault_stack,
    output logic [AW-1:0] lin_addr,
    output logic          rd_ok,
    output logic          wr_ok
);
    logic [AW-1:0] span;
    logic          full_fault, fast_fault, use_fast, invalid_pm, verdict;
    logic          grant_rd, grant_wr;

    assign span = {{(AW-2){1'b0}}, size_span(acc_size)};

    seg_full_check #(.AW(AW), .SUB_W(SUB_W)) u_full (
        .is_write       (is_write),
        .prot_mode      (prot_mode),
        .desc_present   (desc_present),
        .desc_code_data (desc_code_data),
        .desc_big       (desc_big),
        .desc_type      (desc_type),
        .limit          (desc_limit),
        .offset         (offset),
        .span           (span),
        .fault          (full_fault)
    );

    seg_fast_check #(.AW(AW)) u_fast (
        .expand_down (desc_type[3:2] == 2'b01),
        .limit       (desc_limit),
        .offset      (offset),
        .span        (span),
        .fault       (fast_fault)
    );

    seg_flag_fsm u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .reload   (reload),
        .grant_rd (grant_rd),
        .grant_wr (grant_wr),
        .rd_ok    (rd_ok),
        .wr_ok    (wr_ok)
    );

    always_comb begin
        use_fast    = is_write ? wr_ok : rd_ok;
        invalid_pm  = prot_mode && !desc_valid;
        verdict     = invalid_pm || (use_fast ? fast_fault : full_fault);
        fault       = req && verdict;
        fault_stack = fault && !invalid_pm && is_stack;
        grant_rd    = req && !verdict && !is_write;
        grant_wr    = req && !verdict && is_write;
        lin_addr    = desc_base + offset;
    end
endmodule

// File: rtl/seg_access_checker_sva.sv
module seg_access_checker_sva (
    input logic clk,
    input logic rst_n,
    input logic reload,
    input logic req,
    input logic is_write,
    input logic is_stack,
    input logic prot_mode,
    input logic desc_valid,
    input logic desc_code_data,
    input logic fault,
    input logic fault_stack,
    input logic rd_ok,
    input logic wr_ok
);
    p_invalid_gp_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req && prot_mode && !desc_valid |-> fault && !fault_stack);

    p_sys_write_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req && prot_mode && desc_valid && is_write && !desc_code_data && !wr_ok |-> fault);

    p_class_r7: assert property (@(posedge clk) disable iff (!rst_n)
        req && fault && !(prot_mode && !desc_valid) |-> fault_stack == is_stack);

    p_reload_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        reload |=> !rd_ok && !wr_ok);

    p_rd_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req && !reload && !is_write && !fault |=> rd_ok);

    p_wr_grant_r8: assert property (@(posedge clk) disable iff (!rst_n)
        req && !reload && is_write && !fault |=> wr_ok);

    p_flag_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !reload && !(req && !fault) |=> $stable(rd_ok) && $stable(wr_ok));

    p_idle_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !req |-> !fault && !fault_stack);
endmodule

bind seg_access_checker seg_access_checker_sva u_sva (.*);

// File: tb/seg_access_checker_bench.sv
`timescale 1ns/1ps
module seg_access_checker_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        reload = 1'b0, req = 1'b0, is_write = 1'b0, is_stack = 1'b0;
    logic [1:0]  acc_size = 2'b00;
    logic        prot_mode = 1'b1, desc_valid = 1'b1, desc_present = 1'b1;
    logic        desc_code_data = 1'b1, desc_big = 1'b0;
    logic [3:0]  desc_type = 4'd2;
    logic [31:0] desc_limit = 32'hFFFF, desc_base = 32'h0, offset = 32'h0;
    logic        fault, fault_stack, rd_ok, wr_ok;
    logic [31:0] lin_addr;

    int checks = 0, fails = 0;
    bit done = 0;
    bit m_rd = 0, m_wr = 0;

    typedef struct {
        string       tag;
        bit          f, st, rd, wr;
        logic [31:0] addr;
    } exp_t;
    exp_t q[$];

    always #2.5 clk = ~clk;

    seg_access_checker u_seg_access_checker (.*);

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    // independent reference using widened sums
    task automatic model(output bit f, output bit st);
        bit [32:0] n1, up;
        bit fast, down, ok;
        n1   = (acc_size == 2'b00) ? 33'd0 : (acc_size == 2'b01) ? 33'd1 : 33'd3;
        fast = is_write ? m_wr : m_rd;
        down = desc_type inside {[4'd4:4'd7]};
        f = 0; st = 0;
        if (!req) return;
        if (prot_mode && !desc_valid) begin f = 1; return; end
        if (fast) begin
            if (down) f = (desc_limit >= offset - n1[31:0]);
            else      f = (offset > desc_limit - n1[31:0]);
        end else begin
            if (prot_mode && !desc_present) f = 1;
            if (prot_mode && is_write && !desc_code_data) f = 1;
            ok = is_write ? (desc_type inside {4'd2, 4'd3, 4'd6, 4'd7})
                          : !(desc_type inside {4'd8, 4'd9, 4'd12, 4'd13});
            if (!ok) f = 1;
            else if (down) begin
                up = desc_big ? 33'hFFFF_FFFF : 33'h0_FFFF;
                if (offset <= desc_limit || {1'b0, offset} + n1 > up) f = 1;
            end else if ({1'b0, offset} + n1 > {1'b0, desc_limit}) f = 1;
        end
        st = f && is_stack;
    endtask

    task automatic push(string tag);
        exp_t e;
        bit f, st;
        model(f, st);
        e.tag = tag; e.f = f; e.st = st; e.rd = m_rd; e.wr = m_wr;
        e.addr = desc_base + offset;
        q.push_back(e);
        if (reload) begin m_rd = 0; m_wr = 0; end
        else if (req && !f) begin
            if (is_write) m_wr = 1; else m_rd = 1;
        end
    endtask

    task automatic access(string tag, bit wr, bit [1:0] sz, logic [31:0] off, bit stk);
        @(negedge clk);
        req = 1; reload = 0; is_write = wr; acc_size = sz; offset = off; is_stack = stk;
        push(tag);
        @(posedge clk); #1;
        req = 0;
    endtask

    task automatic do_reload(string tag);
        @(negedge clk);
        req = 0; reload = 1;
        push(tag);
        @(posedge clk); #1;
        reload = 0;
    endtask

    task automatic set_d(bit v, bit p, bit s, bit big, logic [3:0] t,
                         logic [31:0] lim, logic [31:0] base);
        desc_valid = v; desc_present = p; desc_code_data = s; desc_big = big;
        desc_type = t; desc_limit = lim; desc_base = base;
    endtask

    // monitor: compares the oldest expectation one step after the drive edge
    initial begin
        forever begin
            @(negedge clk); #1;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (fault !== e.f || fault_stack !== e.st || lin_addr !== e.addr ||
                    rd_ok !== e.rd || wr_ok !== e.wr) begin
                    fails++;
                    $display("FAIL %s: got f=%0b st=%0b a=%h rd=%0b wr=%0b exp f=%0b st=%0b a=%h rd=%0b wr=%0b",
                             e.tag, fault, fault_stack, lin_addr, rd_ok, wr_ok,
                             e.f, e.st, e.addr, e.rd, e.wr);
                end
            end
        end
    end

    initial begin
        #(100000 * 5);
        if (!done) begin
            checks++; fails++;
            $display("FAIL watchdog: got running exp finished");
            summary();
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        @(negedge clk); #1;
        checks++;
        if (rd_ok !== 0 || wr_ok !== 0 || fault !== 0) begin
            fails++;
            $display("FAIL R8 reset: got rd=%0b wr=%0b f=%0b exp 0 0 0", rd_ok, wr_ok, fault);
        end

        // R4 R10 expand-up boundary then short check (R9)
        set_d(1, 1, 1, 0, 4'd3, 32'hFFFF, 32'h1000);
        do_reload("R8 reload");
        access("R4 up edge pass", 0, 2'b10, 32'hFFFC, 0);
        access("R9 up fast over", 0, 2'b10, 32'hFFFD, 0);
        access("R11 size11 as 4", 0, 2'b11, 32'hFFFC, 0);
        do_reload("R8 reload clears");
        access("R4 R7 up over stack", 0, 2'b10, 32'hFFFD, 1);
        set_d(1, 1, 1, 0, 4'd2, 32'h1, 32'h0);
        access("R4 span beyond limit", 0, 2'b10, 32'h0, 0);
        // R5 expand-down
        set_d(1, 1, 1, 0, 4'd6, 32'h0FFF, 32'h0);
        do_reload("R8 reload");
        access("R5 down at limit", 0, 2'b00, 32'h0FFF, 0);
        access("R5 down above 16b bound", 0, 2'b01, 32'hFFFF, 1);
        access("R5 down over bound", 0, 2'b00, 32'h12345, 0);
        access("R5 down pass", 0, 2'b00, 32'h1000, 0);
        access("R9 down fast low edge", 0, 2'b01, 32'h1000, 0);
        access("R9 down fast past bound", 0, 2'b00, 32'h20000, 0);
        set_d(1, 1, 1, 1, 4'd6, 32'h0FFF, 32'h0);
        do_reload("R8 reload");
        access("R5 down big pass", 0, 2'b01, 32'hFFFF, 0);
        // R6 R3 writes
        set_d(1, 1, 1, 0, 4'd0, 32'hFFFF, 32'h0);
        do_reload("R8 reload");
        access("R6 write ro type", 1, 2'b00, 32'h10, 0);
        set_d(1, 1, 0, 0, 4'd2, 32'hFFFF, 32'h0);
        access("R3 write system seg", 1, 2'b00, 32'h10, 0);
        prot_mode = 0;
        access("R12 real mode ignores S", 1, 2'b00, 32'h10, 0);
        prot_mode = 1;
        do_reload("R8 reload");
        set_d(1, 1, 1, 0, 4'd10, 32'hFFFF, 32'h0);
        access("R6 read exec type", 0, 2'b01, 32'h20, 0);
        access("R6 write exec type", 1, 2'b01, 32'h20, 1);
        do_reload("R8 reload");
        set_d(1, 1, 1, 0, 4'd8, 32'hFFFF, 32'h0);
        access("R6 read exec-only", 0, 2'b00, 32'h20, 0);
        // R1 R2 R12
        set_d(0, 1, 1, 0, 4'd2, 32'hFFFF, 32'h0);
        access("R1 invalid gp", 0, 2'b00, 32'h20, 1);
        prot_mode = 0;
        access("R12 real invalid ok", 0, 2'b00, 32'h20, 0);
        prot_mode = 1;
        access("R1 invalid with flag", 0, 2'b00, 32'h20, 1);
        do_reload("R8 reload");
        set_d(1, 0, 1, 0, 4'd2, 32'hFFFF, 32'h0);
        access("R2 absent stack", 0, 2'b00, 32'h20, 1);
        access("R2 absent gp", 1, 2'b00, 32'h20, 0);
        // R10 wrap
        set_d(1, 1, 1, 1, 4'd2, 32'hFFFF_FFFF, 32'hFFFF_FFF0);
        access("R10 wrap address", 1, 2'b10, 32'h20, 0);
        access("R11 write fast", 1, 2'b00, 32'h30, 0);
        @(negedge clk);
        req = 0; reload = 0;
        push("R11 idle");
        @(posedge clk); #1;
        repeat (3) @(posedge clk);
        done = 1;
        summary();
        $finish;
    end
endmodule